// File: doc/BRIEF.md
# Smartcard Transmit Frame Sender with Card Error Sensing

This block sends one byte at a time over a half-duplex, open-drain serial line of the kind used with contact smartcards. Each frame has a low start bit, eight data bits least significant first, an even parity bit and a stop period one and a half bits long. Bit timing comes from an oversample tick enable: one bit lasts sixteen ticks. The block releases the line in the stop period so that the card can pull it low to report a parity error.

The receive path stays active while the block transmits. It reads the line back and decides each data and parity bit by a 2-of-3 vote over the middle three oversample ticks of the bit, so that a line stuck or disturbed by the card shows up as an echo error. During the stop period it takes three further samples about one bit time in. A low majority there is reported as a card error indication, but only when error sensing was enabled for the frame. Each frame ends with a one-cycle done pulse that carries both per-frame results.

Top module: `sc_nack_tx`

## Requirements
- R1: After reset the block is idle: `tx_ready` is 1, `line_oe` is 0 (line released), and `frame_done`, `nack_error` and `echo_error` are 0.
- R2: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1; from the next cycle `tx_ready` stays 0 until the frame's done pulse.
- R3: The frame drives the line through `line_oe` (1 = pull low, 0 = release): a start bit with `line_oe`=1 for 16 ticks, then data bits 0 to 7 in that order, 16 ticks each, with `line_oe` equal to the inverse of the bit.
- R4: After data bit 7 a parity bit of 16 ticks is sent whose value is the XOR of the eight data bits (even parity), with `line_oe` equal to its inverse.
- R5: After the parity bit the line is released (`line_oe`=0) for a stop period of 24 ticks.
- R6: `frame_done` is a one-cycle pulse in the cycle after the edge that processes the 24th stop tick (the 184th tick of the frame); `tx_ready` returns to 1 in that same cycle.
- R7: With error sensing enabled, the line is sampled at the 16th, 17th and 18th tick of the stop period; if at least two of those samples are low, `nack_error` is 1 during the done pulse.
- R8: A single low sample among those three, or low line levels at stop ticks outside them, gives `nack_error`=0.
- R9: The `nack_en` level is taken with the byte; when it was 0, `nack_error` stays 0 even if the card holds the line low through the whole sampling window.
- R10: Each data and parity bit is read back at its 8th, 9th and 10th tick and decided by a 2-of-3 vote; if any decided bit differs from the bit sent, `echo_error` is 1 during the done pulse, otherwise 0. A single disturbed sample does not change the decision.
- R11: Between ticks the frame does not advance: while `tick_en` is 0 during a frame, `line_oe` holds its value.
- R12: `nack_error` and `echo_error` are 0 in every cycle where `frame_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversample tick enable, 16 ticks per bit |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block is idle and accepts a byte |
| nack_en | input | 1 | Enable card error sensing for the offered frame |
| line_in | input | 1 | Sampled level of the serial line |
| line_oe | output | 1 | 1 pulls the open-drain line low |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| nack_error | output | 1 | Card error seen, valid with `frame_done` |
| echo_error | output | 1 | Read-back mismatch, valid with `frame_done` |

## Verification
All timing is counted in processed ticks from the acceptance edge: bit b (start = 0) occupies ticks 16b+1 to 16b+16, its read-back samples fall on ticks 16b+8 to 16b+10, the card samples on ticks 176 to 178 and the done pulse follows the edge of tick 184. The bench keeps its own tick counter reset on the same acceptance edge, drives the card's pull from a per-tick mask so that the line is low exactly at the chosen processing edges, and reads `line_oe` at the middle of each bit and the results at the first falling edge after tick 184. Pull patterns cover the full window, two of three, one of three, and ticks just outside the window, plus read-back faults on a data bit and on the parity bit.

// File: rtl/sc_nack_pkg.sv
package sc_nack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } sc_state_e;

endpackage

// File: rtl/sc_vote3.sv
module sc_vote3 (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic din,
    output logic vote
);
    logic [2:0] smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (sample_en) begin
            smp_d = {smp_q[1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 3'b111;
        end else begin
            smp_q <= smp_d;
        end
    end

    // 2-of-3 majority over the last three captured samples
    assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);

endmodule

// File: rtl/sc_frame_fsm.sv
module sc_frame_fsm
    import sc_nack_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              nack_en,
    input  logic              vote,
    output logic              sample_en,
    output logic              line_oe,
    output logic              frame_done,
    output logic              nack_error,
    output logic              echo_error
);
    localparam int STOP_T = OSR + OSR / 2;
    localparam int CNT_W  = $clog2(STOP_T);
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_T - 1);
    localparam logic [CNT_W-1:0] MID_LO    = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] MID_HI    = CNT_W'(OSR / 2 + 1);
    localparam logic [CNT_W-1:0] NAK_LO    = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] NAK_HI    = CNT_W'(OSR + 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        sc_state_e         state;
        logic [CNT_W-1:0]  tick;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        logic              nak_en;
        logic              echo_acc;
        logic              done;
        logic              nak_out;
        logic              echo_out;
    } fsm_t;

    fsm_t d, q;
    logic last_tick;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.nak_out  = 1'b0;
        d.echo_out = 1'b0;
        last_tick  = (q.state == ST_STOP) ? (q.tick == STOP_LAST) : (q.tick == BIT_LAST);

        if (q.state == ST_IDLE) begin
            if (tx_valid) begin
                d.state    = ST_START;
                d.tick     = '0;
                d.idx      = '0;
                d.shreg    = tx_data;
                d.par      = ^tx_data;
                d.nak_en   = nack_en;
                d.echo_acc = 1'b0;
            end
        end else if (tick_en) begin
            if (!last_tick) begin
                d.tick = q.tick + 1'b1;
            end else begin
                d.tick = '0;
                case (q.state)
                    ST_START: d.state = ST_DATA;
                    ST_DATA: begin
                        d.echo_acc = q.echo_acc | (vote != q.shreg[0]);
                        d.shreg    = q.shreg >> 1;
                        if (q.idx == IDX_LAST) begin
                            d.state = ST_PAR;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        d.echo_acc = q.echo_acc | (vote != q.par);
                        d.state    = ST_STOP;
                    end
                    ST_STOP: begin
                        d.state    = ST_IDLE;
                        d.done     = 1'b1;
                        d.nak_out  = q.nak_en & ~vote;
                        d.echo_out = q.echo_acc;
                    end
                    default: d.state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sample_en = 1'b0;
        if (tick_en) begin
            if (q.state == ST_STOP) begin
                sample_en = (q.tick >= NAK_LO) && (q.tick <= NAK_HI);
            end else if (q.state == ST_DATA || q.state == ST_PAR) begin
                sample_en = (q.tick >= MID_LO) && (q.tick <= MID_HI);
            end
        end
    end

    assign line_oe    = (q.state == ST_START) ||
                        (q.state == ST_DATA && !q.shreg[0]) ||
                        (q.state == ST_PAR  && !q.par);
    assign tx_ready   = (q.state == ST_IDLE);
    assign frame_done = q.done;
    assign nack_error = q.nak_out;
    assign echo_error = q.echo_out;

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !line_oe);

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_stop_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STOP) |-> !line_oe);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !tick_en) |=> $stable(line_oe));

    assert_results_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_error || echo_error) |-> frame_done);

endmodule

// File: rtl/sc_nack_tx.sv
module sc_nack_tx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              nack_en,
    input  logic              line_in,
    output logic              line_oe,
    output logic              frame_done,
    output logic              nack_error,
    output logic              echo_error
);
    logic sample_en;
    logic vote;

    sc_vote3 u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .din       (line_in),
        .vote      (vote)
    );

    sc_frame_fsm #(
        .DATA_W (DATA_W),
        .OSR    (OSR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .nack_en    (nack_en),
        .vote       (vote),
        .sample_en  (sample_en),
        .line_oe    (line_oe),
        .frame_done (frame_done),
        .nack_error (nack_error),
        .echo_error (echo_error)
    );

endmodule

// File: tb/test_sc_nack_tx.sv
`timescale 1ns/1ps
module test_sc_nack_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       nack_en = 1'b0;
    logic       line_in;
    logic       line_oe;
    logic       frame_done;
    logic       nack_error;
    logic       echo_error;

    logic [1:0]   div = 2'd0;
    logic [7:0]   gtick = 8'hFF;
    logic [7:0]   gnext;
    logic [255:0] mask = '0;
    logic         card_low;
    int           n_chk = 0;
    int           n_err = 0;
    bit           ended = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) div <= div + 2'd1;
    assign tick_en = (div == 2'd3);

    // bench tick counter: 0 at acceptance, +1 per processed tick
    always_ff @(posedge clk) begin
        if (tx_valid && tx_ready) gtick <= 8'd0;
        else if (tick_en && gtick != 8'hFF) gtick <= gtick + 8'd1;
    end
    assign gnext    = gtick + 8'd1;
    assign card_low = mask[gnext];
    assign line_in  = ~(line_oe | card_low);

    sc_nack_tx i_sc_nack_tx (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .nack_en(nack_en), .line_in(line_in), .line_oe(line_oe),
        .frame_done(frame_done), .nack_error(nack_error), .echo_error(echo_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] span(input int lo, input int hi);
        logic [255:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic wait_tick(input int t);
        while (gtick != 8'(t)) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] dat, input logic en, input logic [255:0] m,
                             input logic exp_nak, input logic exp_echo);
        logic expb;
        logic held;
        @(negedge clk);
        tx_data  = dat;
        nack_en  = en;
        mask     = m;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        nack_en  = 1'b0;
        chk("R2 ready low after accept", tx_ready, 0);
        for (int b = 0; b < 10; b++) begin
            wait_tick(16 * b + 8);
            if (b == 0)      expb = 1'b1;
            else if (b <= 8) expb = ~dat[b-1];
            else             expb = ~(^dat);
            if (b == 9) chk("R4 parity bit drive", line_oe, expb);
            else        chk("R3 start/data bit drive", line_oe, expb);
            if (b == 1) begin
                held = line_oe;
                @(negedge clk);
                if (gtick == 8'(16 * b + 8)) chk("R11 hold between ticks", line_oe, held);
            end
        end
        wait_tick(170);
        chk("R5 stop released", line_oe, 0);
        chk("R2 ready low mid-stop", tx_ready, 0);
        wait_tick(183);
        chk("R6 no done before last tick", frame_done, 0);
        chk("R12 nack quiet without done", nack_error, 0);
        wait_tick(184);
        chk("R6 done after tick 184", frame_done, 1);
        chk("R6 ready back", tx_ready, 1);
        chk("R7/R8/R9 nack result", nack_error, exp_nak);
        chk("R10 echo result", echo_error, exp_echo);
        @(negedge clk);
        chk("R6 done single cycle", frame_done, 0);
        chk("R12 echo quiet without done", echo_error, 0);
        mask = '0;
    endtask

    task automatic t_reset;
        chk("R1 ready", tx_ready, 1);
        chk("R1 line released", line_oe, 0);
        chk("R1 done", frame_done, 0);
        chk("R1 nack", nack_error, 0);
        chk("R1 echo", echo_error, 0);
    endtask

    task automatic t_format;
        run_frame(8'hA5, 1'b1, '0, 1'b0, 1'b0);
        run_frame(8'h3B, 1'b1, '0, 1'b0, 1'b0);
    endtask

    task automatic t_nack_full;  run_frame(8'h5C, 1'b1, span(176, 178), 1'b1, 1'b0); endtask
    task automatic t_nack_two;   run_frame(8'h12, 1'b1, span(177, 178), 1'b1, 1'b0); endtask
    task automatic t_nack_one;   run_frame(8'h12, 1'b1, span(176, 176), 1'b0, 1'b0); endtask
    task automatic t_nack_outside;
        run_frame(8'hC3, 1'b1, span(170, 175) | span(179, 184), 1'b0, 1'b0);
    endtask
    task automatic t_nack_off;   run_frame(8'h77, 1'b0, span(165, 184), 1'b0, 1'b0); endtask
    task automatic t_echo_data;  run_frame(8'hFF, 1'b0, span(72, 74), 1'b0, 1'b1); endtask
    task automatic t_echo_one;   run_frame(8'hFF, 1'b0, span(73, 73), 1'b0, 1'b0); endtask
    task automatic t_echo_par;   run_frame(8'h01, 1'b1, span(152, 153), 1'b0, 1'b1); endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_format();
        t_nack_full();
        t_nack_two();
        t_nack_one();
        t_nack_outside();
        t_nack_off();
        t_echo_data();
        t_echo_one();
        t_echo_par();
        if (!ended) begin
            ended = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule